// File: doc/BRIEF.md
# Reference Current Calibration Sequencer

This block runs the digital side of a bank of compensated reference currents. A single global DAC sets the base current of output 0. Each further output, numbered 1 to N, has its own local trim DAC. One analog chain compares one output at a time with its reference: a current multiplier, an external resistor and a comparator. The block steers that chain through an analog mux and reads back a single comparator bit. It holds every DAC code in a saturating up/down counter and decides when each loop has converged.

After reset or a start pulse, every code returns to mid-scale. The block first trims the global code against output 0. It then trims outputs 1 to N one at a time, each against output 0. When every output has been trimmed, it enables delivery to the current mirrors, freezes the local codes and returns the mux to output 0. From then on it runs only the global loop, so that slow voltage and temperature drift moves all outputs together. Each code may change at most once per settle interval, which gives the analog path time to settle before the comparator is read.

Top module: `iref_cal_seq`

## Requirements
- R1: After reset or a one-cycle `start` pulse, all codes equal mid-scale (2^(CODE_W-1), which is 32 for the default width), `mux_sel` is 0, `deliver_en` is 0 and `sat_err` is all zeros. A `start` pulse takes effect at the next clock edge, also in the middle of a run.
- R2: The comparator bit `cmp_hi` = 1 means the selected current is at or above its reference, and the selected code then steps down by one. `cmp_hi` = 0 steps the code up by one. Only the code picked by `mux_sel` moves.
- R3: Let K = `settle_cycles`, with 0 treated as 1. Successive updates of a code are exactly K cycles apart. The first update after a restart or a loop hand-over comes K+1 cycles after the edge that applied it.
- R4: A calibration loop ends on the update at which the step direction has reversed TOGGLES times (default 4). That final update does not step. When the comparator trips at codes of T and above, this leaves the code at T if T is at most mid-scale, and at T-1 otherwise.
- R5: If a calibration loop asks to step past 0 or past the full-scale value, the loop ends with the code at that bound. The error bit of that output is then set: bit 0 for the global loop, bit i for local output i. Counters never wrap.
- R6: Calibration runs in the order global (`mux_sel` = 0), then local 1, 2, ..., N (`mux_sel` = i). During the local loops the global code does not change.
- R7: After local output N completes, `deliver_en` goes to 1 and `mux_sel` returns to 0. From then on the local codes stay frozen.
- R8: While `deliver_en` is 1, the global code follows the comparator by at most one step per settle interval. This tracking never terminates and sets no error bit.
- R9: The local codes appear on `local_code`, with output i in bits [(i-1)*CODE_W +: CODE_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restarts the whole sequence from the global loop |
| settle_cycles | input | SETTLE_W | Cycles between code updates (0 acts as 1) |
| cmp_hi | input | 1 | Shared comparator: 1 = selected current at or above reference |
| mux_sel | output | SEL_W | Output routed to the comparator (0 = output 0) |
| global_code | output | CODE_W | Global DAC code |
| local_code | output | N_OUT*CODE_W | Packed local DAC codes, output i at slice i-1 |
| deliver_en | output | 1 | Enables all copies to their mirrors; tracking active |
| sat_err | output | N_OUT+1 | Per-output saturation flag (bit 0 = global) |

## Verification
The assertions watch every cycle for the properties that hold at all times. Counters never wrap past their bounds. The global code stays put while local outputs are being trimmed, and the local codes stay frozen once delivery starts. Tracking steps are at most one. With K above 1, two updates never come in adjacent cycles. Delivery only ever occurs with the mux on output 0, and every restart lands on mid-scale. Only the bench scenarios can show the things that depend on the analog model. These are the exact spacing of K cycles and the first-update latency, the order of the mux hand-overs, the end code after four direction reversals, the error bits after saturation at either rail, and the global code following a moving target during tracking.

// File: rtl/iref_cal_pkg.sv
package iref_cal_pkg;
   typedef enum logic [1:0] {
      PH_GLOBAL = 2'd0,
      PH_LOCAL  = 2'd1,
      PH_TRACK  = 2'd2
   } cal_phase_e;
endpackage

// File: rtl/iref_settle_timer.sv
module iref_settle_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] interval,
   output logic             fire
);
   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("iref_settle_timer: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] span;

   // a zero interval behaves as one cycle
   assign span = (interval == '0) ? CNT_W'(1) : interval;
   assign fire = (cnt_q >= span - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (clr || fire)  cnt_q <= '0;
      else                   cnt_q <= cnt_q + CNT_W'(1);
   end

   AST_UPDATE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && interval > CNT_W'(1)) |=> (!fire || interval <= CNT_W'(1))); // R3
endmodule

// File: rtl/iref_code_reg.sv
module iref_code_reg #(
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_mid,
   input  logic              inc,
   input  logic              dec,
   output logic [CODE_W-1:0] code
);
   localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
   localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

   generate
      if (CODE_W < 2) begin : g_bad_w
         $error("iref_code_reg: CODE_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    code <= MID;
      else if (load_mid)             code <= MID;
      else if (inc && code != FULL)  code <= code + CODE_W'(1);
      else if (dec && code != '0)    code <= code - CODE_W'(1);
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load_mid) |-> (code != FULL)); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load_mid) |-> (code != '0)); // R5
   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec)); // R2
endmodule

// File: rtl/iref_loop_judge.sv
module iref_loop_judge #(
   parameter int CODE_W  = 6,
   parameter int TOGGLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fire,
   input  logic              track,
   input  logic              cmp_hi,
   input  logic [CODE_W-1:0] code,
   output logic              step_up,
   output logic              step_dn,
   output logic              done,
   output logic              sat
);
   localparam int TOG_W = $clog2(TOGGLES + 1);
   localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

   generate
      if (TOGGLES < 1) begin : g_bad_tog
         $error("iref_loop_judge: TOGGLES must be at least 1");
      end
   endgenerate

   logic             have_q;
   logic             last_up_q;
   logic [TOG_W-1:0] tog_q;
   logic             want_up;
   logic             reversed;
   logic [TOG_W-1:0] tog_nx;
   logic             settled;
   logic             at_rail;
   logic             move;

   assign want_up  = ~cmp_hi;
   assign reversed = have_q && (want_up != last_up_q);
   assign tog_nx   = tog_q + TOG_W'(reversed);
   assign settled  = !track && reversed && (tog_nx == TOG_W'(TOGGLES));
   assign at_rail  = want_up ? (code == FULL) : (code == '0);

   assign done    = fire && !track && (settled || at_rail);
   assign sat     = fire && !track && !settled && at_rail;
   assign move    = fire && !at_rail && (track || !settled);
   assign step_up = move && want_up;
   assign step_dn = move && !want_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_q    <= 1'b0;
         last_up_q <= 1'b0;
         tog_q     <= '0;
      end else if (clr) begin
         have_q    <= 1'b0;
         last_up_q <= 1'b0;
         tog_q     <= '0;
      end else if (fire) begin
         have_q    <= 1'b1;
         last_up_q <= want_up;
         if (!track) tog_q <= tog_nx;
      end
   end

   AST_TOGGLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      tog_q < TOG_W'(TOGGLES)); // R4
endmodule

// File: rtl/iref_cal_seq.sv
module iref_cal_seq
   import iref_cal_pkg::*;
#(
   parameter int N_OUT    = 3,
   parameter int CODE_W   = 6,
   parameter int SETTLE_W = 8,
   parameter int TOGGLES  = 4,
   localparam int SEL_W   = $clog2(N_OUT + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [SETTLE_W-1:0]     settle_cycles,
   input  logic                    cmp_hi,
   output logic [SEL_W-1:0]        mux_sel,
   output logic [CODE_W-1:0]       global_code,
   output logic [N_OUT*CODE_W-1:0] local_code,
   output logic                    deliver_en,
   output logic [N_OUT:0]          sat_err
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

   generate
      if (N_OUT < 1) begin : g_bad_n
         $error("iref_cal_seq: N_OUT must be at least 1");
      end
   endgenerate

   cal_phase_e        phase_q;
   logic [SEL_W-1:0]  sel_q;
   logic [N_OUT:0]    err_q;
   logic              fire;
   logic              loop_clr;
   logic              track;
   logic              step_up, step_dn, done, sat;
   logic [CODE_W-1:0] code_q [0:N_OUT];
   logic [CODE_W-1:0] sel_code;

   assign track    = (phase_q == PH_TRACK);
   assign loop_clr = start || done;
   assign sel_code = code_q[sel_q];

   iref_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (loop_clr),
      .interval (settle_cycles),
      .fire     (fire)
   );

   iref_loop_judge #(.CODE_W(CODE_W), .TOGGLES(TOGGLES)) u_judge (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (loop_clr),
      .fire    (fire && !start),
      .track   (track),
      .cmp_hi  (cmp_hi),
      .code    (sel_code),
      .step_up (step_up),
      .step_dn (step_dn),
      .done    (done),
      .sat     (sat)
   );

   generate
      for (genvar gi = 0; gi <= N_OUT; gi++) begin : g_code
         iref_code_reg #(.CODE_W(CODE_W)) u_code (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_mid (start),
            .inc      (step_up && sel_q == SEL_W'(gi)),
            .dec      (step_dn && sel_q == SEL_W'(gi)),
            .code     (code_q[gi])
         );
         if (gi > 0) begin : g_pack
            assign local_code[(gi-1)*CODE_W +: CODE_W] = code_q[gi];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_GLOBAL;
         sel_q   <= '0;
         err_q   <= '0;
      end else if (start) begin
         phase_q <= PH_GLOBAL;
         sel_q   <= '0;
         err_q   <= '0;
      end else if (done) begin
         if (sat) err_q[sel_q] <= 1'b1;
         unique case (phase_q)
            PH_GLOBAL: begin
               phase_q <= PH_LOCAL;
               sel_q   <= SEL_W'(1);
            end
            PH_LOCAL: begin
               if (sel_q == SEL_W'(N_OUT)) begin
                  phase_q <= PH_TRACK;
                  sel_q   <= '0;
               end else begin
                  sel_q <= sel_q + SEL_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign mux_sel     = sel_q;
   assign global_code = code_q[0];
   assign deliver_en  = track;
   assign sat_err     = err_q;

   AST_RESTART_MID: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) |-> (global_code == MID && !deliver_en && mux_sel == '0 && sat_err == '0)); // R1
   AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mux_sel <= SEL_W'(N_OUT)); // R6
   AST_GLOBAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_LOCAL && $past(phase_q == PH_LOCAL) && !$past(start)) |-> $stable(global_code)); // R6
   AST_DELIVER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      deliver_en |-> (mux_sel == '0)); // R7
   AST_LOCAL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_en && $past(deliver_en)) |-> $stable(local_code)); // R7
   AST_TRACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_en && $past(deliver_en)) |->
         (global_code == $past(global_code) ||
          global_code == $past(global_code) + CODE_W'(1) ||
          global_code == $past(global_code) - CODE_W'(1))); // R8
   AST_TRACK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver_en && $past(deliver_en)) |-> $stable(sat_err)); // R8
endmodule

// File: tb/tb_iref_cal_seq.sv
module tb_iref_cal_seq;
   localparam int N = 3;
   localparam int W = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [7:0]     settle_cycles = 8'd3;
   logic           cmp_hi;
   logic [1:0]     mux_sel;
   logic [W-1:0]   global_code;
   logic [N*W-1:0] local_code;
   logic           deliver_en;
   logic [N:0]     sat_err;

   int tgt [0:N];
   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #5 clk = ~clk;

   iref_cal_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
      .cmp_hi(cmp_hi), .mux_sel(mux_sel), .global_code(global_code),
      .local_code(local_code), .deliver_en(deliver_en), .sat_err(sat_err)
   );

   function automatic int lc(input int i);
      return int'(local_code[(i-1)*W +: W]);
   endfunction

   // analog model: comparator trips when the selected code reaches its target
   always_comb begin
      if (mux_sel == 2'd0) cmp_hi = (int'(global_code) >= tgt[0]);
      else                 cmp_hi = (lc(int'(mux_sel)) >= tgt[mux_sel]);
   end

   function automatic int settled_code(input int t);
      return (t <= 32) ? t : t - 1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_deliver(input string req);
      int n = 0;
      while (!deliver_en && n < 20000) begin
         @(negedge clk);
         n++;
      end
      check(deliver_en, req, n, 20000);
   endtask

   // R1: reset state
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(global_code == 6'd32, "R1 global mid", global_code, 32);
      check(local_code == {3{6'd32}}, "R1 locals mid", local_code, {3{6'd32}});
      check(mux_sel == 0, "R1 sel", mux_sel, 0);
      check(!deliver_en, "R1 deliver", deliver_en, 0);
      check(sat_err == 0, "R1 err", sat_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R4 R6 R7 R9: full calibration with order and hold checks
   task automatic t_full_cal();
      int seq [0:7];
      int ns = 1;
      int held_bad = 0;
      int g_hold = -1;
      int prev_sel;
      tgt[0] = 40; tgt[1] = 20; tgt[2] = 32; tgt[3] = 50;
      settle_cycles = 8'd3;
      pulse_start();
      seq[0] = int'(mux_sel);
      prev_sel = int'(mux_sel);
      for (int n = 0; n < 20000 && !deliver_en; n++) begin
         @(negedge clk);
         if (int'(mux_sel) != prev_sel) begin
            if (ns < 8) seq[ns] = int'(mux_sel);
            ns++;
            prev_sel = int'(mux_sel);
            if (prev_sel == 1) g_hold = int'(global_code);
         end
         if (mux_sel != 0 && g_hold >= 0 && int'(global_code) != g_hold) held_bad++;
      end
      check(deliver_en, "R7 deliver after last local", deliver_en, 1);
      check(ns == 5, "R6 hand-over count", ns, 5);
      check(seq[0] == 0 && seq[1] == 1 && seq[2] == 2 && seq[3] == 3 && seq[4] == 0,
            "R6 select order", seq[1]*100 + seq[2]*10 + seq[3], 123);
      check(held_bad == 0, "R6 global held in local phase", held_bad, 0);
      check(int'(global_code) == settled_code(40), "R4 global end", global_code, settled_code(40));
      check(lc(1) == settled_code(20), "R4 R9 local1 end", lc(1), settled_code(20));
      check(lc(2) == settled_code(32), "R4 R9 local2 end", lc(2), settled_code(32));
      check(lc(3) == settled_code(50), "R4 R9 local3 end", lc(3), settled_code(50));
      check(sat_err == 0, "R5 no error", sat_err, 0);
      check(mux_sel == 0, "R7 sel back to 0", mux_sel, 0);
   endtask

   // R2 R3: update spacing and step direction in the global loop
   task automatic t_spacing(input int k);
      int keff = (k == 0) ? 1 : k;
      int last_chg = -1;
      int first_chg = -1;
      int gap_bad = 0;
      int step_bad = 0;
      int first_delta = 0;
      int prev;
      tgt[0] = 40; tgt[1] = 32; tgt[2] = 32; tgt[3] = 32;
      settle_cycles = 8'(k);
      pulse_start();
      prev = int'(global_code);
      for (int c = 1; c < 400 && mux_sel == 0 && !deliver_en; c++) begin
         if (int'(global_code) != prev) begin
            if (first_chg < 0) begin
               first_chg = c;
               first_delta = int'(global_code) - prev;
            end else if (c - last_chg != keff) gap_bad++;
            if (int'(global_code) - prev != 1 && prev - int'(global_code) != 1) step_bad++;
            last_chg = c;
            prev = int'(global_code);
         end
         @(negedge clk);
      end
      check(first_chg == keff + 1, "R3 first update latency", first_chg, keff + 1);
      check(gap_bad == 0, "R3 update spacing", gap_bad, 0);
      check(step_bad == 0, "R2 single steps", step_bad, 0);
      check(first_delta == 1, "R2 low comparator steps up", first_delta, 1);
      wait_deliver("R3 run completes");
   endtask

   // R5: saturation at both rails
   task automatic t_saturate();
      tgt[0] = 70; tgt[1] = 0; tgt[2] = 20; tgt[3] = 32;
      settle_cycles = 8'd2;
      pulse_start();
      wait_deliver("R5 run completes");
      check(global_code == 6'd63, "R5 global at full scale", global_code, 63);
      check(lc(1) == 0, "R5 local1 at zero", lc(1), 0);
      check(lc(2) == 20, "R5 local2 normal", lc(2), 20);
      check(sat_err == 4'b0011, "R5 error bits", sat_err, 3);
      repeat (20) @(negedge clk);
      check(global_code == 6'd63 && sat_err == 4'b0011, "R8 no wrap or error in tracking",
            sat_err, 3);
   endtask

   // R1: start in the middle of a run restarts everything
   task automatic t_restart();
      tgt[0] = 40; tgt[1] = 20; tgt[2] = 32; tgt[3] = 50;
      settle_cycles = 8'd2;
      pulse_start();
      for (int n = 0; n < 5000 && mux_sel != 2; n++) @(negedge clk);
      check(mux_sel == 2, "R6 reached local2", mux_sel, 2);
      pulse_start();
      check(global_code == 6'd32 && local_code == {3{6'd32}}, "R1 restart codes mid",
            global_code, 32);
      check(mux_sel == 0 && !deliver_en, "R1 restart sel and deliver", mux_sel, 0);
      wait_deliver("R1 rerun completes");
      check(int'(global_code) == settled_code(40) && lc(3) == settled_code(50),
            "R1 rerun result", global_code, settled_code(40));
   endtask

   // R8: tracking follows a moving target, locals frozen
   task automatic t_tracking();
      int k = 4;
      int prev;
      int saved;
      int last_chg = -1;
      int bad = 0;
      settle_cycles = 8'(k);
      saved = int'(local_code);
      tgt[0] = 36;
      prev = int'(global_code);
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         if (int'(global_code) != prev) begin
            if (int'(global_code) - prev != 1 && prev - int'(global_code) != 1) bad++;
            if (last_chg >= 0 && c - last_chg < k) bad++;
            last_chg = c;
            prev = int'(global_code);
         end
      end
      check(bad == 0, "R8 tracking step and spacing", bad, 0);
      check(global_code == 6'd35 || global_code == 6'd36, "R8 tracks new target",
            global_code, 36);
      check(int'(local_code) == saved, "R7 locals frozen in tracking", local_code, saved);
      check(deliver_en && mux_sel == 0, "R8 still delivering", deliver_en, 1);
   endtask

   initial begin
      tgt[0] = 32; tgt[1] = 32; tgt[2] = 32; tgt[3] = 32;
      @(negedge clk);
      t_reset();
      t_full_cal();
      t_tracking();
      t_spacing(5);
      t_spacing(0);
      t_saturate();
      t_restart();
      finish_run();
   end
endmodule